// File: doc/BRIEF.md
# Full-Bridge Gate Sequencer with Fault Hold

This block produces the four gate-enable signals for one full bridge. The bridge has two legs, and each leg has a high switch and a low switch. A bridge enable and one level input per leg select the state of each leg. With the bridge enabled, a high level input turns on that leg's high switch, which drives the leg's output to supply. A low level input turns on the low switch, which drives the output to ground. With the bridge disabled, all four switches are off and both outputs float. Both levels high and both levels low are braking states and are accepted as normal operation.

Inside a leg, the block never hands conduction straight from one switch to the other. Whenever a switch is released, including when the bridge is disabled, both switches of that leg stay off for a programmable number of clock cycles before either one is turned on again. A digital fault pulse, standing for an overcurrent or overtemperature detection, switches everything off on the next clock edge and starts a fault-hold interval. A further fault during that interval starts the interval again. When the interval has expired, the enable input has to qualify once more before the legs return to normal operation.

The enable has hysteresis. It is dropped on the first low sample. It is accepted only after a parameterised number of consecutive high samples, and none of those samples may fall while a fault or the hold is present.

Top module: `hbridge_gate_seq`

## Requirements
- R1: Whenever `en_i` is sampled low at a clock edge, all four gate outputs are low after that edge, whatever the two level inputs are.
- R2: While the bridge is enabled and a leg has settled, that leg has only its high gate on when its level input is 1 and only its low gate on when its level input is 0. The two legs follow their own inputs independently.
- R3: Both level inputs at 1, or both at 0, put the matching gate on in both legs at the same time, and no fault state results.
- R4: In a leg, the high and low gates are never on in the same cycle, and an on gate is never followed directly by its partner in the next cycle.
- R5: In a leg, any gate turn-on is preceded by at least DEAD_CYC consecutive cycles with both gates off. A level change on an enabled leg releases the on gate at the first edge and turns the partner on exactly DEAD_CYC edges later.
- R6: After the enable has qualified, the first gate turn-on also waits DEAD_CYC edges. From a steady low, a rise on `en_i` gives the first gate EN_QUAL + DEAD_CYC edges after the first high sample.
- R7: The enable is accepted only after EN_QUAL consecutive high samples that also see no fault and no hold. A high pulse shorter than that turns no gate on.
- R8: A `fault_i` sample at 1 turns all gates off after that edge and sets `hold_o` after that same edge.
- R9: `hold_o` stays high for exactly HOLD_CYC cycles after the last fault sample. A fault during the hold restarts the count, and all gates stay off while `hold_o` is high.
- R10: After the hold expires, normal operation resumes only through a fresh enable qualification (R7) followed by the dead time (R6).
- R11: A synchronous reset (`rst` high at an edge) sets all gate outputs low, clears the hold, and clears the enable qualification.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Bridge enable request |
| fault_i | input | 1 | Overcurrent or overtemperature fault pulse |
| lvl_a_i | input | 1 | Level request for leg A (1 = supply, 0 = ground) |
| lvl_b_i | input | 1 | Level request for leg B (1 = supply, 0 = ground) |
| gate_hi_a_o | output | 1 | Leg A high switch on |
| gate_lo_a_o | output | 1 | Leg A low switch on |
| gate_hi_b_o | output | 1 | Leg B high switch on |
| gate_lo_b_o | output | 1 | Leg B low switch on |
| hold_o | output | 1 | Fault-hold interval active |

## Verification
Every result is registered, and the timing differs by result.
- A fault, or a low enable sample, shows on the gates and on `hold_o` one edge after it is sampled.
- A level change releases the on gate one edge after it is sampled and turns the partner on DEAD_CYC edges after that.
- An enable rise first shows on the gates EN_QUAL + DEAD_CYC edges after the first high sample.

The bench drives inputs on the falling edge and runs its own cycle model of these rules on the rising edge. It compares all outputs at the next falling edge, so each value is sampled in the cycle it becomes due. Separate monitors watch the gate outputs. They measure every both-off gap against DEAD_CYC, and they measure the exact turn-on delay after enable and the exact width of the hold.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

    // Conduction state of one bridge leg.
    typedef enum logic [1:0] {
        LEG_FLOAT = 2'd0,
        LEG_HIGH  = 2'd1,
        LEG_LOW   = 2'd2
    } leg_mode_e;

    // Number of legs in a full bridge.
    localparam int unsigned NUM_LEGS = 2;

endpackage

// File: rtl/hbs_enable_guard.sv
module hbs_enable_guard #(
    parameter int unsigned HOLD_CYC = 5000,
    parameter int unsigned EN_QUAL  = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic fault_i,
    output logic kill_o,
    output logic hold_o
);

    localparam int unsigned HW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam int unsigned QW = (EN_QUAL > 1) ? $clog2(EN_QUAL) : 1;
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYC - 1);
    localparam logic [QW-1:0] QUAL_LAST = QW'(EN_QUAL - 1);

    typedef struct packed {
        logic          hold;
        logic [HW-1:0] hold_cnt;
        logic [QW-1:0] qual_cnt;
        logic          en_eff;
    } guard_t;

    guard_t st_d, st_q;
    logic   qualify;

    always_comb begin
        st_d    = st_q;
        qualify = en_i && !fault_i && !st_q.hold;

        // Fault hold: a fault (re)loads the counter, otherwise it runs down.
        if (fault_i) begin
            st_d.hold     = 1'b1;
            st_d.hold_cnt = HOLD_LAST;
        end else if (st_q.hold) begin
            if (st_q.hold_cnt == '0) begin
                st_d.hold = 1'b0;
            end else begin
                st_d.hold_cnt = st_q.hold_cnt - 1'b1;
            end
        end

        // Enable hysteresis: slow to assert, immediate to drop.
        if (qualify) begin
            if (st_q.qual_cnt != QUAL_LAST) begin
                st_d.qual_cnt = st_q.qual_cnt + 1'b1;
            end
        end else begin
            st_d.qual_cnt = '0;
        end
        st_d.en_eff = qualify && (st_q.en_eff || (st_q.qual_cnt == QUAL_LAST));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign kill_o = !en_i || fault_i || !st_q.en_eff;
    assign hold_o = st_q.hold;

    AST_FAULT_SETS_HOLD: assert property (@(posedge clk) disable iff (rst)
        fault_i |=> hold_o); // R8

    AST_HOLD_ENDS_QUIET: assert property (@(posedge clk) disable iff (rst)
        $fell(hold_o) |-> $past(!fault_i)); // R9

    AST_HOLD_NO_ENABLE: assert property (@(posedge clk) disable iff (rst)
        hold_o |-> !st_q.en_eff); // R10

    AST_LOW_EN_DROPS: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> !st_q.en_eff); // R7

endmodule

// File: rtl/hbs_leg_seq.sv
module hbs_leg_seq
    import hbs_pkg::*;
#(
    parameter int unsigned DEAD_CYC = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic kill_i,
    input  logic lvl_i,
    output logic hi_o,
    output logic lo_o
);

    localparam int unsigned DW = $clog2(DEAD_CYC + 1);
    localparam logic [DW-1:0] DEAD_V = DW'(DEAD_CYC);

    typedef struct packed {
        leg_mode_e     mode;
        logic [DW-1:0] run;
    } leg_t;

    leg_t          st_d, st_q;
    logic [DW-1:0] run_inc;

    always_comb begin
        st_d    = st_q;
        run_inc = (st_q.run == DEAD_V) ? st_q.run : st_q.run + 1'b1;

        if (kill_i) begin
            st_d.mode = LEG_FLOAT;
            st_d.run  = '0;
        end else begin
            unique case (st_q.mode)
                LEG_HIGH: begin
                    if (!lvl_i) begin
                        st_d.mode = LEG_FLOAT;
                        st_d.run  = '0;
                    end
                end
                LEG_LOW: begin
                    if (lvl_i) begin
                        st_d.mode = LEG_FLOAT;
                        st_d.run  = '0;
                    end
                end
                default: begin
                    st_d.run = run_inc;
                    if (run_inc >= DEAD_V) begin
                        st_d.mode = lvl_i ? LEG_HIGH : LEG_LOW;
                        st_d.run  = '0;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{mode: LEG_FLOAT, run: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign hi_o = (st_q.mode == LEG_HIGH);
    assign lo_o = (st_q.mode == LEG_LOW);

    // Observer: consecutive both-off cycles seen on the outputs.
    logic [DW-1:0] gap_mon_q;
    always_ff @(posedge clk) begin
        if (rst || hi_o || lo_o) begin
            gap_mon_q <= '0;
        end else if (gap_mon_q != DEAD_V) begin
            gap_mon_q <= gap_mon_q + 1'b1;
        end
    end

    AST_NO_DIRECT_FLIP_HI: assert property (@(posedge clk) disable iff (rst)
        hi_o |=> !lo_o); // R4

    AST_NO_DIRECT_FLIP_LO: assert property (@(posedge clk) disable iff (rst)
        lo_o |=> !hi_o); // R4

    AST_DEAD_GAP: assert property (@(posedge clk) disable iff (rst)
        $rose(hi_o || lo_o) |-> (gap_mon_q >= DEAD_V)); // R5

    AST_KILL_OFF: assert property (@(posedge clk) disable iff (rst)
        kill_i |=> !(hi_o || lo_o)); // R1

endmodule

// File: rtl/hbridge_gate_seq.sv
module hbridge_gate_seq
    import hbs_pkg::*;
#(
    parameter int unsigned DEAD_CYC = 50,
    parameter int unsigned HOLD_CYC = 5000,
    parameter int unsigned EN_QUAL  = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic fault_i,
    input  logic lvl_a_i,
    input  logic lvl_b_i,
    output logic gate_hi_a_o,
    output logic gate_lo_a_o,
    output logic gate_hi_b_o,
    output logic gate_lo_b_o,
    output logic hold_o
);

    logic                kill;
    logic [NUM_LEGS-1:0] lvl_v;
    logic [NUM_LEGS-1:0] hi_v;
    logic [NUM_LEGS-1:0] lo_v;

    assign lvl_v = {lvl_b_i, lvl_a_i};

    hbs_enable_guard #(
        .HOLD_CYC (HOLD_CYC),
        .EN_QUAL  (EN_QUAL)
    ) u_guard (
        .clk     (clk),
        .rst     (rst),
        .en_i    (en_i),
        .fault_i (fault_i),
        .kill_o  (kill),
        .hold_o  (hold_o)
    );

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        hbs_leg_seq #(
            .DEAD_CYC (DEAD_CYC)
        ) u_leg (
            .clk    (clk),
            .rst    (rst),
            .kill_i (kill),
            .lvl_i  (lvl_v[g]),
            .hi_o   (hi_v[g]),
            .lo_o   (lo_v[g])
        );
    end

    assign gate_hi_a_o = hi_v[0];
    assign gate_lo_a_o = lo_v[0];
    assign gate_hi_b_o = hi_v[1];
    assign gate_lo_b_o = lo_v[1];

    AST_HOLD_GATES_OFF: assert property (@(posedge clk) disable iff (rst)
        hold_o |-> ((hi_v | lo_v) == '0)); // R9

    AST_FAULT_GATES_OFF: assert property (@(posedge clk) disable iff (rst)
        fault_i |=> ((hi_v | lo_v) == '0)); // R8

endmodule

// File: tb/tb_hbridge_gate_seq.sv
module tb_hbridge_gate_seq;

    localparam int CLK_PERIOD = 10;
    localparam int DEAD = 4;
    localparam int HOLD = 20;
    localparam int QUAL = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic fault = 1'b0;
    logic lvl_a = 1'b0;
    logic lvl_b = 1'b0;
    logic hi_a, lo_a, hi_b, lo_b, hold;

    int checks = 0;
    int fails = 0;
    string tag = "R11";

    hbridge_gate_seq #(.DEAD_CYC(DEAD), .HOLD_CYC(HOLD), .EN_QUAL(QUAL)) dut (
        .clk(clk), .rst(rst), .en_i(en), .fault_i(fault),
        .lvl_a_i(lvl_a), .lvl_b_i(lvl_b),
        .gate_hi_a_o(hi_a), .gate_lo_a_o(lo_a),
        .gate_hi_b_o(hi_b), .gate_lo_b_o(lo_b), .hold_o(hold)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Reference model built from the requirements (0 float, 1 high, 2 low).
    int m_run = 0, m_left = 0;
    bit m_eff = 0;
    int m_mode[2] = '{0, 0};
    int m_cnt[2] = '{0, 0};

    function automatic int gates_of(int mode);
        return (mode == 1) ? 2 : (mode == 2) ? 1 : 0;   // {hi,lo}
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_run = 0; m_eff = 0; m_left = 0;
            for (int l = 0; l < 2; l++) begin m_mode[l] = 0; m_cnt[l] = 0; end
        end else begin
            bit ok, kill, d;
            ok   = en && !fault && (m_left == 0);
            kill = !en || fault || !m_eff;
            m_run = ok ? ((m_run < QUAL) ? m_run + 1 : QUAL) : 0;
            m_eff = (m_run >= QUAL);
            if (fault) m_left = HOLD; else if (m_left > 0) m_left--;
            for (int l = 0; l < 2; l++) begin
                d = (l == 0) ? lvl_a : lvl_b;
                if (kill) begin m_mode[l] = 0; m_cnt[l] = 0; end
                else if ((m_mode[l] == 1 && !d) || (m_mode[l] == 2 && d)) begin
                    m_mode[l] = 0; m_cnt[l] = 0;
                end else if (m_mode[l] == 0) begin
                    m_cnt[l]++;
                    if (m_cnt[l] >= DEAD) begin m_mode[l] = d ? 1 : 2; m_cnt[l] = 0; end
                end
            end
        end
    end

    // Per-cycle comparison plus independent gap and overlap monitors.
    int off_len[2] = '{0, 0};
    bit was_on[2] = '{0, 0};

    always @(negedge clk) begin
        int act, exp;
        act = {hi_a, lo_a, hi_b, lo_b, hold};
        exp = {gates_of(m_mode[0])[1:0], gates_of(m_mode[1])[1:0], (m_left > 0)};
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: outputs {hiA,loA,hiB,loB,hold} actual %05b expected %05b",
                     tag, act[4:0], exp[4:0]);
        end
        for (int l = 0; l < 2; l++) begin
            bit h, o;
            h = (l == 0) ? hi_a : hi_b;
            o = (l == 0) ? lo_a : lo_b;
            if (h && o) begin
                checks++; fails++;
                $display("FAIL R4: leg %0d both gates on, actual 11 expected not 11", l);
            end
            if ((h || o) && !was_on[l]) begin
                checks++;
                if (off_len[l] < DEAD) begin
                    fails++;
                    $display("FAIL R5: leg %0d gap actual %0d expected >= %0d", l, off_len[l], DEAD);
                end
            end
            was_on[l] = h || o;
            off_len[l] = (h || o) ? 0 : off_len[l] + 1;
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_eq(string t, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", t, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        finish_run();
    end

    initial begin
        int n;
        void'($urandom(32'd20240611));
        // R11: reset state, fault ignored while in reset
        fault = 1'b1; en = 1'b1; lvl_a = 1'b1;
        step(3);
        expect_eq("R11 gates in reset", {hi_a, lo_a, hi_b, lo_b}, 0);
        expect_eq("R11 hold in reset", hold, 0);
        fault = 1'b0; en = 1'b0;
        rst = 1'b0;
        step(2);

        // R1: enable low, every level pattern, nothing turns on
        tag = "R1";
        for (int p = 0; p < 4; p++) begin
            lvl_a = p[0]; lvl_b = p[1];
            step(DEAD + 2);
            expect_eq("R1 gates off with enable low", {hi_a, lo_a, hi_b, lo_b}, 0);
        end

        // R6: enable rise to first gate takes QUAL + DEAD edges
        tag = "R6";
        lvl_a = 1'b1; lvl_b = 1'b0;
        en = 1'b1;
        n = 0;
        for (int k = 1; k <= 30; k++) begin
            step(1);
            if (hi_a) begin n = k; break; end
        end
        expect_eq("R6 enable-to-gate edges", n, QUAL + DEAD);

        // R2: settled independent legs
        tag = "R2";
        expect_eq("R2 leg A high, leg B low", {hi_a, lo_a, hi_b, lo_b}, 4'b1001);

        // R5: level change, partner on exactly DEAD edges after release
        tag = "R5";
        lvl_a = 1'b0;
        step(1);
        expect_eq("R5 released at first edge", {hi_a, lo_a}, 0);
        step(DEAD - 1);
        expect_eq("R5 still off before dead time", {hi_a, lo_a}, 0);
        step(1);
        expect_eq("R5 partner on after dead time", {hi_a, lo_a}, 2'b01);

        // R3: braking states
        tag = "R3";
        lvl_a = 1'b1; lvl_b = 1'b1;
        step(DEAD + 2);
        expect_eq("R3 both high", {hi_a, lo_a, hi_b, lo_b, hold}, 5'b10100);
        lvl_a = 1'b0; lvl_b = 1'b0;
        step(DEAD + 2);
        expect_eq("R3 both low", {hi_a, lo_a, hi_b, lo_b, hold}, 5'b01010);

        // R1: enable drop is seen after one edge
        tag = "R1";
        en = 1'b0;
        step(1);
        expect_eq("R1 drop after one edge", {hi_a, lo_a, hi_b, lo_b}, 0);

        // R7: enable pulse shorter than qualification
        tag = "R7";
        lvl_a = 1'b1;
        en = 1'b1; step(QUAL - 1); en = 1'b0;
        step(DEAD + QUAL + 4);
        expect_eq("R7 short pulse no gate", {hi_a, lo_a, hi_b, lo_b}, 0);

        // R8 / R9: fault, hold width
        tag = "R8";
        en = 1'b1;
        step(QUAL + DEAD + 2);
        fault = 1'b1; step(1); fault = 1'b0;
        expect_eq("R8 gates off after fault", {hi_a, lo_a, hi_b, lo_b}, 0);
        expect_eq("R8 hold set", hold, 1);
        tag = "R9";
        n = 1;
        while (hold && n < 200) begin step(1); if (hold) n++; end
        expect_eq("R9 hold width", n, HOLD);

        // R10: resumption after hold needs qualification plus dead time
        tag = "R10";
        n = 0;
        for (int k = 1; k <= 30; k++) begin
            if (hi_a) break;
            n = k; step(1);
        end
        expect_eq("R10 resume edges after hold", n, QUAL + DEAD);

        // R9: fault inside the hold restarts the count
        tag = "R9";
        fault = 1'b1; step(1); fault = 1'b0;
        step(7);
        fault = 1'b1; step(1); fault = 1'b0;
        n = 1;
        while (hold && n < 200) begin step(1); if (hold) n++; end
        expect_eq("R9 restarted hold width", n, HOLD);

        // R11: reset while driving
        tag = "R11";
        step(QUAL + DEAD + 3);
        rst = 1'b1; step(1);
        expect_eq("R11 mid-run reset", {hi_a, lo_a, hi_b, lo_b, hold}, 0);
        rst = 1'b0;

        // R2: constrained random traffic against the model
        tag = "R2";
        for (int c = 0; c < 20000; c++) begin
            if ($urandom_range(0, 29) == 0) lvl_a = ~lvl_a;
            if ($urandom_range(0, 29) == 0) lvl_b = ~lvl_b;
            if ($urandom_range(0, 199) == 0) en = 1'b0;
            else if ($urandom_range(0, 7) == 0) en = 1'b1;
            fault = ($urandom_range(0, 1499) == 0);
            step(1);
        end
        fault = 1'b0;
        step(2);
        finish_run();
    end

endmodule